// File: doc/BRIEF.md
# Decimal Accumulator Processor Core

This block is a small multi-cycle processor for a machine whose instructions are three-digit decimal words in the range 000 to 999. The leading digit of a word picks the operation and the last two digits give an address or an operand field. The core holds three working registers (A, B, C), a program counter and a condition register. Unlike a flag-based design, the condition register keeps the whole signed value last written to any register. Instructions and data live in an external 30-word memory that the core reaches through a request/valid port.

The core leaves reset halted, with the program counter at 10. A pulse on `run_i` starts execution from the current PC. Execution continues until a halt instruction is reached. When `step_i` is held high, the core stops after each completed instruction, and each new `run_i` pulse advances it by one instruction. A testbench or a surrounding controller preloads memory, starts the core, and reads the results from the register outputs and the memory.

Top module: `dacc_core`

## Requirements
- R1: After reset `halted_o` is 1, `pc_o` is 10, A, B, C and CC are 0, and no memory request is made while halted.
- R2: A `run_i` pulse while halted starts fetching at PC. Each fetch advances PC by one, and PC wraps from 29 to 0. Any two-digit address or target above 29 is reduced modulo 30. This applies to operands, to branch targets and to the second word of a conditional branch.
- R3: 1aa loads A with word aa. 3aa adds word aa to A. 4aa subtracts word aa from A. In each case CC takes the new A.
- R4: 2aa writes the non-negative residue of A modulo 1000 (range 0 to 999) to word aa. A, B, C and CC are unchanged, so a store of -1 writes 999.
- R5: 5aa sets PC to aa and leaves CC and all registers unchanged.
- R6: 6aa is a conditional branch and behaves according to the sign of CC:
  - CC > 0: PC becomes aa.
  - CC < 0: PC skips the following word, so it becomes n+2 for the branch at n.
  - CC = 0: the core reads the following word bb with a second memory access and sets PC to bb.
- R7: 7mp transfers a register. Digit m selects the source change: 2 adds 1, 0 subtracts 1, and any other value leaves the source as it is. The changed value is first written back to the source and then copied to the destination. Digit p selects the (source, destination) pair:

  | p | Source | Destination |
  |---|--------|-------------|
  | 0 | A | A |
  | 1 | A | B |
  | 2 | A | C |
  | 3 | B | A |
  | 4 | B | B |
  | 5 | B | C |
  | 6 | C | A |
  | 7 | C | B |
  | 8 | C | C |
  | 9 | PC (already n+1) | A |

  CC takes the copied value.
- R8: 8ii loads B with the value ii (0 to 99), and CC takes ii.
- R9: A word whose leading digit is 0 or 9 halts the core. PC is left one past the halt word, and the registers are unchanged.
- R10: With `step_i` high, exactly one instruction completes per `run_i` pulse. The core then halts with PC naming the next instruction to execute.
- R11: `mem_req_o` stays high with stable address, write enable and write data until `mem_rvalid_i` acknowledges it. `mem_we_o` is raised only for stores.
- R12: A register write updates CC even when the value is unchanged. For example, 710 copies A into CC after CC held another value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Start or resume pulse, honoured while halted |
| step_i | input | 1 | Halt after every completed instruction |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W (5) | Word address 0..29 |
| mem_wdata_o | output | 10 | Store data 0..999 |
| mem_rvalid_i | input | 1 | Access completed; read data valid |
| mem_rdata_i | input | 10 | Read data |
| halted_o | output | 1 | Core is halted |
| pc_o | output | ADDR_W (5) | Program counter |
| reg_a_o | output | DATA_W (32) | Register A, signed |
| reg_b_o | output | DATA_W (32) | Register B, signed |
| reg_c_o | output | DATA_W (32) | Register C, signed |
| cc_o | output | DATA_W (32) | Condition register, signed |

## Verification
A corrupted instruction register or a decode error shows up on the register, CC or PC outputs after the instruction in question completes. The single-step checks catch it within one instruction of its cause. A wrong CC value stays hidden until a conditional branch consumes it, and it then surfaces as a wrong PC. The per-step comparison of CC closes that gap. A broken memory handshake appears within a few cycles, either as a dropped request or as an address that changes before the acknowledge.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  localparam int WORD_W   = 10;
  localparam int WORD_MOD = 1000;
  localparam int NREG     = 3;
  localparam int FIELD_W  = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_DATA} state_e;
  typedef enum logic [1:0] {SEL_A = 2'd0, SEL_B = 2'd1, SEL_C = 2'd2, SEL_PC = 2'd3} rsel_e;

  localparam logic [3:0] OP_LOAD  = 4'd1;
  localparam logic [3:0] OP_STORE = 4'd2;
  localparam logic [3:0] OP_ADD   = 4'd3;
  localparam logic [3:0] OP_SUB   = 4'd4;
  localparam logic [3:0] OP_JMP   = 4'd5;
  localparam logic [3:0] OP_BCC   = 4'd6;
  localparam logic [3:0] OP_XFER  = 4'd7;
  localparam logic [3:0] OP_LDB   = 4'd8;

  function automatic logic [3:0] lead_digit(input logic [WORD_W-1:0] w);
    return 4'(w / 10'd100);
  endfunction

  function automatic logic [FIELD_W-1:0] low_field(input logic [WORD_W-1:0] w);
    return FIELD_W'(w % 10'd100);
  endfunction

  function automatic logic [NREG-1:0] sel_bit(input rsel_e s);
    case (s)
      SEL_A:   return 3'b001;
      SEL_B:   return 3'b010;
      SEL_C:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/dacc_regs.sv
module dacc_regs
  import dacc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NREG-1:0]             wr_mask_i,
  input  logic [DATA_W-1:0]           wr_val_i,
  output logic [NREG-1:0][DATA_W-1:0] regs_o,
  output logic [DATA_W-1:0]           cc_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           regs_o[g] <= '0;
      else if (wr_mask_i[g]) regs_o[g] <= wr_val_i;
    end
  end

  // CC follows every register write, value-holding rather than flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cc_o <= '0;
    else if (|wr_mask_i) cc_o <= wr_val_i;
  end
endmodule

// File: rtl/dacc_xfer.sv
module dacc_xfer
  import dacc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int MEM_WORDS = 30
) (
  input  logic [FIELD_W-1:0] field_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [DATA_W-1:0]  c_i,
  input  logic [ADDR_W-1:0]  pc_i,
  output rsel_e              src_o,
  output rsel_e              dst_o,
  output logic [DATA_W-1:0]  val_o,
  output logic [ADDR_W-1:0]  pc_o
);
  localparam logic [ADDR_W-1:0] PC_LAST = ADDR_W'(MEM_WORDS - 1);

  logic [3:0]        m_dig, p_dig;
  logic              inc, dec;
  logic [DATA_W-1:0] src_val;

  assign m_dig = 4'(field_i / 7'd10);
  assign p_dig = 4'(field_i % 7'd10);
  assign inc   = (m_dig == 4'd2);
  assign dec   = (m_dig == 4'd0);

  always_comb begin
    if (p_dig >= 4'd9) begin
      src_o = SEL_PC;
      dst_o = SEL_A;
    end else begin
      src_o = rsel_e'(2'(p_dig / 4'd3));
      dst_o = rsel_e'(2'(p_dig % 4'd3));
    end
  end

  always_comb begin
    case (src_o)
      SEL_A:   src_val = a_i;
      SEL_B:   src_val = b_i;
      default: src_val = c_i;
    endcase
  end

  always_comb begin
    pc_o = pc_i;
    if (inc)      pc_o = (pc_i == PC_LAST) ? '0 : pc_i + 1'b1;
    else if (dec) pc_o = (pc_i == '0) ? PC_LAST : pc_i - 1'b1;
  end

  always_comb begin
    if (src_o == SEL_PC) val_o = DATA_W'(pc_o);
    else if (inc)        val_o = src_val + 1'b1;
    else if (dec)        val_o = src_val - 1'b1;
    else                 val_o = src_val;
  end
endmodule

// File: rtl/dacc_ctrl.sv
module dacc_ctrl
  import dacc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int MEM_WORDS = 30,
  parameter int RESET_PC  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               step_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [WORD_W-1:0]  mem_wdata_o,
  input  logic               mem_rvalid_i,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  cc_i,
  input  rsel_e              x_src_i,
  input  rsel_e              x_dst_i,
  input  logic [DATA_W-1:0]  x_val_i,
  input  logic [ADDR_W-1:0]  x_pc_i,
  output logic [FIELD_W-1:0] field_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic               halted_o,
  output logic [NREG-1:0]    wr_mask_o,
  output logic [DATA_W-1:0]  wr_val_o
);
  localparam logic [ADDR_W-1:0] PC_LAST  = ADDR_W'(MEM_WORDS - 1);
  localparam logic [ADDR_W-1:0] PC_START = ADDR_W'(RESET_PC);

  state_e              state_q;
  logic [ADDR_W-1:0]   pc_q, pc_inc, ea, bb_tgt;
  logic [WORD_W-1:0]   ir_q;
  logic [3:0]          op;
  logic                is_mem_op, done_next;
  logic [DATA_W-1:0]   rem, rdata_ext;
  logic signed [DATA_W-1:0] cc_s;

  assign op        = lead_digit(ir_q);
  assign field_o   = low_field(ir_q);
  assign ea        = ADDR_W'(field_o % FIELD_W'(MEM_WORDS));
  assign bb_tgt    = ADDR_W'(mem_rdata_i % WORD_W'(MEM_WORDS));
  assign pc_inc    = (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
  assign is_mem_op = (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ADD) || (op == OP_SUB);
  assign cc_s      = $signed(cc_i);
  assign rdata_ext = DATA_W'(mem_rdata_i);
  assign pc_o      = pc_q;
  assign halted_o  = (state_q == ST_IDLE);

  // store residue kept in 0..999 for negative accumulator values
  assign rem = DATA_W'($signed(a_i) % $signed(DATA_W'(WORD_MOD)));
  always_comb begin
    if ($signed(rem) < 0) mem_wdata_o = WORD_W'(rem + DATA_W'(WORD_MOD));
    else                  mem_wdata_o = WORD_W'(rem);
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = pc_q;
    case (state_q)
      ST_FETCH: mem_req_o = 1'b1;
      ST_DATA: begin
        mem_req_o  = 1'b1;
        mem_we_o   = (op == OP_STORE);
        mem_addr_o = (op == OP_BCC) ? pc_q : ea;
      end
      default: ;
    endcase
  end

  assign done_next = step_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= PC_START;
      ir_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (run_i) state_q <= ST_FETCH;
        ST_FETCH: if (mem_rvalid_i) begin
          ir_q    <= mem_rdata_i;
          pc_q    <= pc_inc;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          state_q <= done_next ? ST_IDLE : ST_FETCH;
          if (is_mem_op) state_q <= ST_DATA;
          else case (op)
            OP_JMP: pc_q <= ea;
            OP_BCC: begin
              if (cc_s > 0)      pc_q <= ea;
              else if (cc_s < 0) pc_q <= pc_inc;
              else               state_q <= ST_DATA;
            end
            OP_XFER: if (x_src_i == SEL_PC) pc_q <= x_pc_i;
            OP_LDB: ;
            default: state_q <= ST_IDLE;
          endcase
        end
        ST_DATA: if (mem_rvalid_i) begin
          if (op == OP_BCC) pc_q <= bb_tgt;
          state_q <= done_next ? ST_IDLE : ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_mask_o = '0;
    wr_val_o  = x_val_i;
    if (state_q == ST_EXEC) begin
      if (op == OP_XFER) begin
        wr_mask_o = sel_bit(x_dst_i) | sel_bit(x_src_i);
      end else if (op == OP_LDB) begin
        wr_mask_o = sel_bit(SEL_B);
        wr_val_o  = DATA_W'(field_o);
      end
    end else if (state_q == ST_DATA && mem_rvalid_i) begin
      case (op)
        OP_LOAD: begin wr_mask_o = sel_bit(SEL_A); wr_val_o = rdata_ext;       end
        OP_ADD:  begin wr_mask_o = sel_bit(SEL_A); wr_val_o = a_i + rdata_ext; end
        OP_SUB:  begin wr_mask_o = sel_bit(SEL_A); wr_val_o = a_i - rdata_ext; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dacc_core.sv
module dacc_core
  import dacc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int MEM_WORDS = 30,
  parameter int RESET_PC  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              step_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              halted_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] reg_a_o,
  output logic [DATA_W-1:0] reg_b_o,
  output logic [DATA_W-1:0] reg_c_o,
  output logic [DATA_W-1:0] cc_o
);
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [NREG-1:0]             wr_mask;
  logic [DATA_W-1:0]           wr_val, x_val;
  logic [FIELD_W-1:0]          field;
  logic [ADDR_W-1:0]           x_pc;
  rsel_e                       x_src, x_dst;

  assign reg_a_o = regs[0];
  assign reg_b_o = regs[1];
  assign reg_c_o = regs[2];

  dacc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_mask_i(wr_mask), .wr_val_i(wr_val),
    .regs_o(regs), .cc_o(cc_o)
  );

  dacc_xfer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u_xfer (
    .field_i(field), .a_i(regs[0]), .b_i(regs[1]), .c_i(regs[2]), .pc_i(pc_o),
    .src_o(x_src), .dst_o(x_dst), .val_o(x_val), .pc_o(x_pc)
  );

  dacc_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS), .RESET_PC(RESET_PC)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .step_i(step_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .a_i(regs[0]), .cc_i(cc_o), .x_src_i(x_src), .x_dst_i(x_dst), .x_val_i(x_val),
    .x_pc_i(x_pc), .field_o(field), .pc_o(pc_o), .halted_o(halted_o),
    .wr_mask_o(wr_mask), .wr_val_o(wr_val)
  );
endmodule

// File: rtl/dacc_core_chk.sv
module dacc_core_chk
  import dacc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int MEM_WORDS = 30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [WORD_W-1:0] mem_wdata_o,
  input logic              mem_rvalid_i,
  input logic              halted_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [DATA_W-1:0] reg_a_o,
  input logic [DATA_W-1:0] cc_o
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R11

  AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (int'(mem_addr_o) < MEM_WORDS)); // R2

  AST_PC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pc_o) < MEM_WORDS); // R2

  AST_HALT_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_req_o); // R1

  AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !run_i |=> halted_o && $stable(pc_o) && $stable(reg_a_o) && $stable(cc_o)); // R10

  AST_STORE_KEEPS_REGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> $stable(reg_a_o) && $stable(cc_o)); // R4

  AST_WDATA_DECIMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (int'(mem_wdata_o) < WORD_MOD)); // R4
endmodule

bind dacc_core dacc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rvalid_i(mem_rvalid_i),
  .halted_o(halted_o), .pc_o(pc_o), .reg_a_o(reg_a_o), .cc_o(cc_o)
);

// File: tb/tb_dacc_core.sv
`timescale 1ns/1ps
module tb_dacc_core;
  localparam int N = 30;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, step = 1'b0;
  logic req, we, halted;
  logic [4:0] addr, pc;
  logic [9:0] wdata;
  logic rvalid = 1'b0;
  logic [9:0] rdata = '0;
  logic [31:0] ra_o, rb_o, rc_o, cc_o;

  logic [9:0] mem [N];
  logic [9:0] img [N];
  logic copy_req = 1'b0;
  int lat = 0;
  int viol = 0;
  logic prev_req = 1'b0, prev_rv = 1'b0;
  logic [4:0] prev_addr = '0;

  int n_chk = 0, n_fail = 0;
  int ra, rb, rc, rcc, rpc;
  int rm [N];
  bit rh;

  always #10 clk = ~clk;

  dacc_core dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .step_i(step),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata), .halted_o(halted), .pc_o(pc),
    .reg_a_o(ra_o), .reg_b_o(rb_o), .reg_c_o(rc_o), .cc_o(cc_o)
  );

  // memory model with 1..3 cycle random latency
  always @(posedge clk) begin
    if (copy_req) begin
      for (int i = 0; i < N; i++) mem[i] <= img[i];
      rvalid <= 1'b0;
    end else if (req && !rvalid) begin
      if (lat == 0) begin
        rvalid <= 1'b1;
        rdata  <= mem[addr];
        if (we) mem[addr] <= wdata;
        lat <= $urandom_range(0, 2);
      end else lat <= lat - 1;
    end else rvalid <= 1'b0;
  end

  // handshake monitor, R11
  always @(posedge clk) begin
    if (rst_n && prev_req && !prev_rv && (!req || addr != prev_addr)) viol <= viol + 1;
    prev_req  <= req;
    prev_rv   <= rvalid;
    prev_addr <= addr;
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic ref_step(output int op);
    int w, f, m, p, d, v;
    v = 0;
    w = rm[rpc];
    rpc = (rpc + 1) % N;
    op = w / 100;
    f = w % 100;
    case (op)
      1: begin ra = rm[f % N]; rcc = ra; end
      2: rm[f % N] = ((ra % 1000) + 1000) % 1000;
      3: begin ra = ra + rm[f % N]; rcc = ra; end
      4: begin ra = ra - rm[f % N]; rcc = ra; end
      5: rpc = f % N;
      6: begin
        if (rcc > 0) rpc = f % N;
        else if (rcc < 0) rpc = (rpc + 1) % N;
        else rpc = rm[rpc] % N;
      end
      7: begin
        m = f / 10; p = f % 10;
        d = (m == 2) ? 1 : (m == 0) ? -1 : 0;
        if (p == 9) begin
          rpc = (rpc + d + N) % N; v = rpc; ra = v;
        end else begin
          case (p / 3)
            0: begin ra = ra + d; v = ra; end
            1: begin rb = rb + d; v = rb; end
            default: begin rc = rc + d; v = rc; end
          endcase
          case (p % 3)
            0: ra = v;
            1: rb = v;
            default: rc = v;
          endcase
        end
        rcc = v;
      end
      8: begin rb = f; rcc = f; end
      default: rh = 1'b1;
    endcase
  endtask

  function automatic string tag_of(int op);
    case (op)
      1, 3, 4: return "R3";
      2: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compare_all(string tag);
    int bad;
    bad = 0;
    chk(tag, "pc", int'(pc), rpc);
    chk(tag, "A", int'(ra_o), ra);
    chk(tag, "B", int'(rb_o), rb);
    chk(tag, "C", int'(rc_o), rc);
    chk(tag, "CC", int'(cc_o), rcc);
    for (int i = 0; i < N; i++) if (int'(mem[i]) != rm[i]) bad++;
    chk(tag, "mem_mismatches", bad, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run = 1'b0; step = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ra = 0; rb = 0; rc = 0; rcc = 0; rpc = 10; rh = 1'b0;
  endtask

  task automatic clear_img();
    for (int i = 0; i < N; i++) img[i] = '0;
  endtask

  task automatic load_img();
    copy_req = 1'b1;
    @(negedge clk);
    copy_req = 1'b0;
    @(negedge clk);
    for (int i = 0; i < N; i++) rm[i] = int'(img[i]);
  endtask

  task automatic go_wait(string tag);
    int t;
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    t = 0;
    while (!halted && t < 5000) begin @(negedge clk); t++; end
    if (!halted) begin
      n_chk++; n_fail++;
      $display("FAIL %s halt_timeout act=0 exp=1", tag);
    end
  endtask

  task automatic run_prog(string tag);
    int op;
    load_img();
    go_wait(tag);
    for (int k = 0; k < 2000 && !rh; k++) ref_step(op);
    compare_all(tag);
  endtask

  initial begin
    void'($urandom(32'd4021));
    fork
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=expired exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
      end
    join_none

    // R1 reset state
    clear_img();
    do_reset();
    chk("R1", "halted", int'(halted), 1);
    chk("R1", "pc", int'(pc), 10);
    chk("R1", "A", int'(ra_o), 0);
    chk("R1", "B", int'(rb_o), 0);
    chk("R1", "CC", int'(cc_o), 0);
    chk("R1", "req", int'(req), 0);

    // R3 sum program: 16+24 stored to 29
    do_reset(); clear_img();
    img[10] = 10'd127; img[11] = 10'd328; img[12] = 10'd229; img[13] = 10'd000;
    img[27] = 10'd16; img[28] = 10'd24;
    run_prog("R3");
    chk("R3", "A_sum", int'(ra_o), 40);
    chk("R9", "pc_after_halt", int'(pc), 14);

    // R6 CC zero: second word read
    do_reset(); clear_img();
    img[10] = 10'd800; img[11] = 10'd615; img[12] = 10'd20; img[20] = 10'd000;
    run_prog("R6");
    chk("R6", "pc_zero_path", int'(pc), 21);

    // R6 CC negative: skip second word
    do_reset(); clear_img();
    img[10] = 10'd700; img[11] = 10'd620; img[12] = 10'd555; img[13] = 10'd000;
    run_prog("R6");
    chk("R6", "pc_neg_path", int'(pc), 14);

    // R6 CC positive: branch to aa
    do_reset(); clear_img();
    img[10] = 10'd805; img[11] = 10'd625; img[25] = 10'd000;
    run_prog("R6");
    chk("R6", "pc_pos_path", int'(pc), 26);

    // R4 negative store residue
    do_reset(); clear_img();
    img[10] = 10'd700; img[11] = 10'd205; img[12] = 10'd000;
    run_prog("R4");
    chk("R4", "mem5", int'(mem[5]), 999);

    // R12 transfer A->A rewrites CC
    do_reset(); clear_img();
    img[0] = 10'd3; img[10] = 10'd100; img[11] = 10'd807; img[12] = 10'd710; img[13] = 10'd000;
    run_prog("R12");
    chk("R12", "cc_rewritten", int'(cc_o), 3);

    // R7 PC source with increment
    do_reset(); clear_img();
    img[10] = 10'd729; img[12] = 10'd000;
    run_prog("R7");
    chk("R7", "A_from_pc", int'(ra_o), 12);

    // R5 R2 folded jump and fetch wrap
    do_reset(); clear_img();
    img[10] = 10'd595; img[5] = 10'd529; img[29] = 10'd801; img[0] = 10'd000;
    run_prog("R5");
    chk("R2", "pc_wrapped", int'(pc), 1);

    // R10 single step through sum program
    do_reset(); clear_img();
    img[10] = 10'd127; img[11] = 10'd328; img[12] = 10'd229; img[13] = 10'd000;
    img[27] = 10'd16; img[28] = 10'd24;
    load_img();
    step = 1'b1;
    for (int k = 0; k < 4; k++) begin
      int op;
      go_wait("R10");
      ref_step(op);
      chk("R10", "pc_step", int'(pc), rpc);
      chk("R10", "A_step", int'(ra_o), ra);
    end

    // random single-step comparison
    do_reset(); clear_img();
    for (int i = 0; i < N; i++) begin
      int opd;
      opd = $urandom_range(0, 8);
      if (opd == 0 && $urandom_range(0, 2) != 0) opd = 7;
      img[i] = 10'(opd * 100 + $urandom_range(0, 99));
    end
    load_img();
    step = 1'b1;
    for (int k = 0; k < 400; k++) begin
      int op;
      go_wait("R10");
      ref_step(op);
      rh = 1'b0;
      compare_all(tag_of(op));
    end

    chk("R11", "handshake_violations", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule